// File: doc/BRIEF.md
# HDLC Serial Frame Transmitter

This block turns a stream of bytes into one serial HDLC-style bit stream. Bytes arrive on a byte-wide port with a valid/ready handshake and an end-of-frame marker. For each frame the block emits an opening flag, the payload bytes, a 16-bit frame check sequence and a closing flag. A zero is inserted after every run of five ones in the payload and the check sequence, so that no flag pattern can appear inside a frame.

The serial output moves one bit for each cycle in which the bit-clock enable is high. Between frames the line carries idle fill. By default this is back-to-back flags. A mode input selects a steady all-ones line instead. A byte presented with the abort request is consumed, and eight ones are sent in its place. If the byte source runs dry before the end-of-frame marker, the block raises an underrun pulse and also ends the frame with the abort pattern.

Top module: `hdlc_framer`

## Requirements
- R1: Each frame opens and closes with the flag byte 0x7E. With `idle_ones` low, the line between frames carries continuous flags.
- R2: Payload bytes are sent least significant bit first.
- R3: After the last payload bit come 16 check bits. They are the ones' complement of a CRC with generator x^16+x^12+x^5+1 (bit-reversed constant 0x8408), preset to 0xFFFF and run over the payload bits. They are sent low-order bit first, and the closing flag follows them. A receiver that runs the same CRC over the payload and the check bits ends with 0xF0B8.
- R4: Within the payload and the check bits, a zero is inserted after every five consecutive ones. This includes a run that ends on the last check bit. Flags and idle fill are never stuffed.
- R5: A byte accepted with `in_abort` high is replaced by eight ones. No check bits and no closing flag follow it, and the line returns to idle fill.
- R6: With `idle_ones` high, the line between frames is held at one.
- R7: `in_ready` is high only in cycles where `bit_en` is high. A byte is transferred when `in_valid` and `in_ready` are both high. The byte that carries `in_last` is the final payload byte.
- R8: If a further byte is needed within a frame while `in_valid` is low, `underrun` pulses for one cycle and the frame is ended with eight ones.
- R9: `tx_bit` changes only in a cycle after `bit_en` was high. While `bit_en` stays low, both the line and the frame state hold.
- R10: In reset, `tx_bit` is one and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable: one serial bit per high cycle |
| idle_ones | input | 1 | Idle fill select: 0 for flags, 1 for all ones |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is present |
| in_last | input | 1 | Byte is the last one of the frame |
| in_abort | input | 1 | Send the abort pattern in place of this byte |
| in_ready | output | 1 | Byte is taken in this cycle |
| tx_bit | output | 1 | Serial line output |
| underrun | output | 1 | One-cycle pulse when the byte source ran dry mid-frame |

## Verification
The assertions assume that the byte source keeps `in_valid` and its byte stable from the moment it is raised until the transfer. They also assume that `in_abort` is only raised together with a valid byte. The transfer and abort properties depend on the state that follows an accepted byte, so these assumptions matter. The bench feeds bytes from a queue that holds each entry on the port until it is taken, and it marks the final byte of every normal frame with `in_last`. It queues each complete frame before the block reaches that frame's first byte, except in the one scenario that deliberately leaves the source empty. The enable is driven at one bit in three cycles, at every cycle, and held low for a stretch, so the checks do not rely on any particular bit rate.

// File: rtl/hdlc_tx_pkg.sv
// Shared definitions for the serial frame transmitter.
// Assumes 8-bit bytes and a 16-bit check sequence.
package hdlc_tx_pkg;
    // Frame sequencer phases
    typedef enum logic [2:0] {
        S_IDLE,
        S_OPEN,
        S_DATA,
        S_CRC,
        S_CLOSE,
        S_ABORT
    } txst_e;

    // Frame delimiter byte
    localparam logic [7:0] FLAG_PAT = 8'h7E;
endpackage

// File: rtl/hdlc_crc16.sv
// Bit-serial CRC accumulator, reflected form, shifting LSB first.
// Assumes the caller clears it before a frame and steps it once per payload bit.
// crc_nxt is the value after the current bit. It lets the caller capture
// the result on the same edge as the final bit.
module hdlc_crc16 #(
    parameter int              CRC_W    = 16,
    parameter logic [CRC_W-1:0] POLY_REV = 16'h8408
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_nxt
);
    logic fb;

    // Next remainder for one incoming bit
    always_comb begin
        fb      = crc_q[0] ^ din;
        crc_nxt = (crc_q >> 1) ^ (fb ? POLY_REV : '0);
    end

    // Remainder register: preset to all ones on clear
    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= '1;
        else if (clear) crc_q <= '1;
        else if (step)  crc_q <= crc_nxt;
    end
endmodule

// File: rtl/hdlc_stuff_cnt.sv
// Counts consecutive ones among stuffable line bits. It requests an
// inserted zero once RUN of them have gone out.
// Assumes tick marks every line bit. Non-stuffable bits clear the count.
module hdlc_stuff_cnt #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic stuffable,
    input  logic bit_val,
    output logic stuff_now
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] cnt;

    // Zero insertion is due when the run reaches its limit
    assign stuff_now = (cnt == CW'(RUN));

    // Run counter, advanced once per line bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            if (stuff_now)                   cnt <= '0;
            else if (stuffable && bit_val)   cnt <= cnt + 1'b1;
            else                             cnt <= '0;
        end
    end

    // R4: the ones run inside a frame never passes the limit
    assert_run_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(RUN));
endmodule

// File: rtl/hdlc_tx_ctrl.sv
// Frame sequencer. It walks through idle fill, opening flag, payload,
// check sequence and closing flag, or through the abort pattern. It picks
// the raw line bit and takes bytes at byte boundaries.
// Assumes in_valid and in_data stay stable until they are taken. Each
// state advances only on a bit-enable cycle with no stuffed zero due.
module hdlc_tx_ctrl
    import hdlc_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              idle_ones,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              in_abort,
    output logic              in_ready,
    input  logic              stuff_now,
    input  logic [CRC_W-1:0]  crc_nxt,
    output logic              crc_clear,
    output logic              crc_step,
    output logic              crc_din,
    output logic              stuffable,
    output logic              raw_bit,
    output logic              emit_bit,
    output logic              underrun
);
    localparam int IW = $clog2(CRC_W);

    txst_e             state;
    logic [IW-1:0]     bit_idx;
    logic [CRC_W-1:0]  shreg;
    logic              cur_last;
    logic              adv;
    logic              last_bit;
    logic              take;
    logic [CRC_W-1:0]  load_val;

    // Raw bit for the current phase and position
    always_comb begin
        case (state)
            S_IDLE:          raw_bit = idle_ones ? 1'b1 : FLAG_PAT[bit_idx[2:0]];
            S_OPEN, S_CLOSE: raw_bit = FLAG_PAT[bit_idx[2:0]];
            S_DATA, S_CRC:   raw_bit = shreg[0];
            default:         raw_bit = 1'b1;
        endcase
    end

    // Handshake, stepping and stuffing controls
    always_comb begin
        stuffable = (state == S_DATA) || (state == S_CRC);
        emit_bit  = stuff_now ? 1'b0 : raw_bit;
        adv       = bit_en && !stuff_now;
        last_bit  = (state == S_CRC) ? (bit_idx == IW'(CRC_W - 1))
                                     : (bit_idx == IW'(DATA_W - 1));
        in_ready  = adv && last_bit &&
                    ((state == S_OPEN) || ((state == S_DATA) && !cur_last));
        take      = in_ready && in_valid;
        crc_clear = (state == S_OPEN);
        crc_step  = adv && (state == S_DATA);
        crc_din   = shreg[0];
        load_val  = {{(CRC_W - DATA_W){1'b0}}, in_data};
    end

    // Phase, bit position, shifter and underrun pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            bit_idx  <= '0;
            shreg    <= '0;
            cur_last <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (adv) begin
                bit_idx <= last_bit ? '0 : bit_idx + 1'b1;
                if (stuffable) shreg <= shreg >> 1;
                case (state)
                    S_IDLE: if (last_bit && in_valid) state <= S_OPEN;
                    S_OPEN, S_DATA: begin
                        if (last_bit) begin
                            if ((state == S_DATA) && cur_last) begin
                                state <= S_CRC;
                                shreg <= ~crc_nxt;
                            end else if (in_valid) begin
                                shreg    <= load_val;
                                cur_last <= in_last;
                                state    <= in_abort ? S_ABORT : S_DATA;
                            end else begin
                                state    <= S_ABORT;
                                underrun <= 1'b1;
                            end
                        end
                    end
                    S_CRC:            if (last_bit) state <= S_CLOSE;
                    S_CLOSE, S_ABORT: if (last_bit) state <= S_IDLE;
                    default:          state <= S_IDLE;
                endcase
            end
        end
    end

    // R7: a byte taken without abort becomes payload
    assert_take_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_abort) |=> (state == S_DATA));
    // R5: a byte taken with abort is replaced by the abort pattern
    assert_take_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_abort) |=> (state == S_ABORT));
    // R5: after the abort pattern the line goes straight back to idle fill
    assert_abort_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_ABORT) && adv && last_bit) |=> (state == S_IDLE));
    // R8: an underrun pulse always coincides with the abort pattern
    assert_underrun_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (state == S_ABORT));
    // R3: the closing flag follows the sixteenth check bit
    assert_crc_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_CRC) && adv && last_bit) |=> (state == S_CLOSE));
endmodule

// File: rtl/hdlc_framer.sv
// Top of the serial frame transmitter. It joins the sequencer, the
// zero-insertion counter and the CRC, and registers the line bit.
// Assumes bit_en marks each serial bit period. The line holds otherwise.
module hdlc_framer #(
    parameter int DATA_W    = 8,
    parameter int CRC_W     = 16,
    parameter int STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              idle_ones,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              in_abort,
    output logic              in_ready,
    output logic              tx_bit,
    output logic              underrun
);
    logic             stuff_now;
    logic             crc_clear;
    logic             crc_step;
    logic             crc_din;
    logic             stuffable;
    logic             raw_bit;
    logic             emit_bit;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;

    hdlc_tx_ctrl #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .idle_ones (idle_ones),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_abort  (in_abort),
        .in_ready  (in_ready),
        .stuff_now (stuff_now),
        .crc_nxt   (crc_nxt),
        .crc_clear (crc_clear),
        .crc_step  (crc_step),
        .crc_din   (crc_din),
        .stuffable (stuffable),
        .raw_bit   (raw_bit),
        .emit_bit  (emit_bit),
        .underrun  (underrun)
    );

    hdlc_stuff_cnt #(.RUN(STUFF_RUN)) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_en),
        .stuffable (stuffable),
        .bit_val   (raw_bit),
        .stuff_now (stuff_now)
    );

    hdlc_crc16 #(.CRC_W(CRC_W)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (crc_clear),
        .step    (crc_step),
        .din     (crc_din),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    // Line register: idles high in reset, moves once per bit enable
    always_ff @(posedge clk) begin
        if (!rst_n)      tx_bit <= 1'b1;
        else if (bit_en) tx_bit <= emit_bit;
    end

    // R9: without a bit enable the line does not move
    assert_line_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));
    // R4: a stuffed zero never leaves the line as one
    assert_stuff_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && stuff_now) |=> !tx_bit);
endmodule

// File: tb/tb_hdlc_framer.sv
// Directed bench: feeds bytes from a queue, decodes the serial line into
// flags, aborts and frames, and checks each scenario in its own task.
module tb_hdlc_framer;
    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       idle_ones = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_abort = 1'b0;
    wire        in_ready;
    wire        tx_bit;
    wire        underrun;

    hdlc_framer dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .idle_ones(idle_ones),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_abort(in_abort), .in_ready(in_ready), .tx_bit(tx_bit),
        .underrun(underrun)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // byte source queue
    logic [7:0] q_data[$];
    bit         q_last[$];
    bit         q_abort[$];
    bit         hs_pending = 0;

    // enable pattern: 0 every cycle, 1 one in three, 2 held low
    int   en_mode = 1;
    int   en_cnt = 0;
    logic en_prev = 1'b0;

    // line decoder state
    int   ones = 0;
    bit   in_frame = 0;
    bit   rbuf[$];
    int   frames = 0;
    int   aborts = 0;
    int   flags = 0;
    int   zeros = 0;
    int   rx_bits = 0;
    int   ready_viol = 0;
    bit   saw_underrun = 0;
    logic [7:0] last_frame[$];
    logic [15:0] last_resid = 16'h0;
    int   last_nbits = 0;
    bq_t  pl;

    function automatic logic [15:0] crc_bit(logic [15:0] c, bit b);
        logic fb;
        fb = c[0] ^ b;
        c  = c >> 1;
        if (fb) c = c ^ 16'h8408;
        return c;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic deliver();
        int n;
        logic [15:0] c;
        logic [7:0] b;
        n = rbuf.size() - 1;
        if (n <= 0) return;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) c = crc_bit(c, rbuf[i]);
        last_resid = c;
        last_nbits = n;
        last_frame.delete();
        for (int i = 0; i + 8 <= n; i += 8) begin
            for (int k = 0; k < 8; k++) b[k] = rbuf[i + k];
            last_frame.push_back(b);
        end
        frames++;
    endtask

    task automatic rx_bit(bit b);
        rx_bits++;
        if (b) begin
            ones++;
            if (ones == 7) begin
                aborts++;
                in_frame = 0;
                rbuf.delete();
            end
        end else begin
            zeros++;
            if (ones == 6) begin
                flags++;
                if (in_frame) deliver();
                in_frame = 1;
                rbuf.delete();
            end else if (ones < 7) begin
                for (int i = 0; i < ones; i++) rbuf.push_back(1'b1);
                if (ones != 5) rbuf.push_back(1'b0);
            end
            ones = 0;
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // per-cycle driver and line monitor, all away from the rising edge
    always begin
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
        if (hs_pending) begin
            void'(q_data.pop_front());
            void'(q_last.pop_front());
            void'(q_abort.pop_front());
        end
        hs_pending = 0;
        if (rst_n && en_prev) rx_bit(tx_bit);
        if (underrun) saw_underrun = 1;
        case (en_mode)
            0:       bit_en = 1'b1;
            1:       bit_en = (en_cnt % 3 == 0);
            default: bit_en = 1'b0;
        endcase
        en_cnt++;
        en_prev = bit_en;
        in_valid = (q_data.size() > 0);
        if (in_valid) begin
            in_data  = q_data[0];
            in_last  = q_last[0];
            in_abort = q_abort[0];
        end else begin
            in_last  = 1'b0;
            in_abort = 1'b0;
        end
        #1;
        if (in_ready && !bit_en) ready_viol++;
        hs_pending = in_valid && in_ready;
    end

    task automatic wait_bits(int n);
        int b0 = rx_bits;
        int t = 0;
        while (rx_bits - b0 < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic push_frame(int abort_at, bit mark_last);
        for (int i = 0; i < pl.size(); i++) begin
            q_data.push_back(pl[i]);
            q_abort.push_back(i == abort_at);
            q_last.push_back(mark_last && (i == pl.size() - 1));
        end
    endtask

    // R10: reset values
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        #2;
        check(tx_bit == 1'b1, "R10", "tx_bit in reset", tx_bit, 1);
        check(in_ready == 1'b0, "R10", "in_ready in reset", in_ready, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: flag idle fill
    task automatic t_idle_flags();
        int f0, fr0, a0;
        wait_bits(12);
        f0 = flags; fr0 = frames; a0 = aborts;
        wait_bits(40);
        check(flags - f0 >= 4, "R1", "idle flags seen", flags - f0, 5);
        check(frames == fr0, "R1", "no frame from idle", frames, fr0);
        check(aborts == a0, "R1", "no abort in flag idle", aborts, a0);
    endtask

    // R1 R2 R3 R4 R7: one complete frame from the payload in pl
    task automatic t_frame(string req);
        int fr0, t;
        logic [15:0] c;
        fr0 = frames;
        push_frame(-1, 1'b1);
        t = 0;
        while (frames == fr0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(frames == fr0 + 1, req, "frame delivered", frames, fr0 + 1);
        check(last_nbits % 8 == 0, req, "bit count multiple of 8", last_nbits, 8 * (pl.size() + 2));
        check(last_frame.size() == pl.size() + 2, req, "frame byte count", last_frame.size(), pl.size() + 2);
        if (last_frame.size() == pl.size() + 2) begin
            for (int i = 0; i < pl.size(); i++)
                check(last_frame[i] == pl[i], req, "payload byte", last_frame[i], pl[i]);
            c = 16'hFFFF;
            foreach (pl[i]) for (int k = 0; k < 8; k++) c = crc_bit(c, pl[i][k]);
            c = ~c;
            check(last_frame[pl.size()] == c[7:0], "R3", "check low byte", last_frame[pl.size()], c[7:0]);
            check(last_frame[pl.size() + 1] == c[15:8], "R3", "check high byte", last_frame[pl.size() + 1], c[15:8]);
        end
        check(last_resid == 16'hF0B8, "R3", "receiver residue", last_resid, 16'hF0B8);
        check(q_data.size() == 0, "R7", "all bytes taken", q_data.size(), 0);
    endtask

    // R5: abort carried with a byte
    task automatic t_abort();
        int fr0, a0, t;
        fr0 = frames; a0 = aborts; saw_underrun = 0;
        pl = {8'h11, 8'h22};
        push_frame(1, 1'b0);
        t = 0;
        while (aborts == a0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        wait_bits(30);
        check(aborts == a0 + 1, "R5", "abort detected", aborts, a0 + 1);
        check(frames == fr0, "R5", "no frame after abort", frames, fr0);
        check(q_data.size() == 0, "R5", "abort byte consumed", q_data.size(), 0);
        check(saw_underrun == 0, "R5", "no underrun on abort", saw_underrun, 0);
    endtask

    // R8: source runs dry mid-frame
    task automatic t_underrun();
        int fr0, a0, t;
        fr0 = frames; a0 = aborts; saw_underrun = 0;
        pl = {8'h5A};
        push_frame(-1, 1'b0);
        t = 0;
        while (aborts == a0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        wait_bits(20);
        check(saw_underrun == 1, "R8", "underrun pulse", saw_underrun, 1);
        check(aborts == a0 + 1, "R8", "abort after underrun", aborts, a0 + 1);
        check(frames == fr0, "R8", "no frame after underrun", frames, fr0);
    endtask

    // R9: enable held low freezes the line mid-frame
    task automatic t_hold();
        logic held;
        int fr0, t, moves;
        fr0 = frames;
        pl = {8'hC3, 8'h3C, 8'h99};
        push_frame(-1, 1'b1);
        wait_bits(20);
        en_mode = 2;
        @(negedge clk);
        @(negedge clk);
        held = tx_bit;
        moves = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tx_bit !== held || in_ready) moves++;
        end
        check(moves == 0, "R9", "line frozen without enable", moves, 0);
        en_mode = 1;
        t = 0;
        while (frames == fr0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(frames == fr0 + 1, "R9", "frame resumes intact", frames, fr0 + 1);
        if (last_frame.size() == 5)
            check(last_frame[2] == 8'h99, "R9", "last payload after stall", last_frame[2], 8'h99);
        check(last_resid == 16'hF0B8, "R9", "residue after stall", last_resid, 16'hF0B8);
    endtask

    // R6: all-ones idle, then a frame still opens with a flag
    task automatic t_idle_ones();
        int z0;
        idle_ones = 1'b1;
        wait_bits(20);
        z0 = zeros;
        wait_bits(40);
        check(zeros == z0, "R6", "zeros on ones idle", zeros - z0, 0);
        pl = {8'hE7, 8'h01};
        t_frame("R6");
        idle_ones = 1'b0;
        wait_bits(20);
    endtask

    initial begin
        t_reset();
        t_idle_flags();
        pl = {8'h12, 8'h34, 8'h56};
        t_frame("R2");
        pl = {8'hFF, 8'hFF, 8'hFF, 8'hFF};
        t_frame("R4");
        pl = {8'h7E, 8'h7E, 8'h7C};
        t_frame("R4");
        en_mode = 0;
        pl = {8'hA5};
        t_frame("R7");
        en_mode = 1;
        t_abort();
        pl = {8'h0F, 8'hF0};
        t_frame("R1");
        t_underrun();
        t_hold();
        t_idle_ones();
        check(ready_viol == 0, "R7", "ready without enable", ready_viol, 0);
        finish_run();
    end
endmodule